// File: doc/BRIEF.md
# Multi-Bank GPIO Register Block

This block is a memory-mapped general-purpose I/O peripheral on a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. It serves four bidirectional banks of 8, 24, 13 and 6 pins. It also has a 29-bit bank of dedicated inputs, a 24-bit bank of dedicated outputs and a 13-bit function-select latch that belongs to bank 2.

Software never writes an output level or a direction directly. It writes a mask to a "set" register, which raises every selected bit, or to a "clear" register, which lowers every selected bit. Separate state registers give the levels back. All pad inputs pass through a two-flop synchroniser before they can be read.

Bank 3 is irregular. Its outputs and the dedicated outputs share one set/clear pair. Its direction bits sit above bank 2's bits in bank 2's direction registers. Its input levels are scattered through the dedicated-input word.

The bus is a control path. It has no valid/ready handshake: a write completes in the cycle its strobe is sampled, and a read returns data in the same cycle.

Top module: `gpio_regblock`

## Requirements
- R1: After reset, every output latch, direction latch and function-select latch is 0, so all pins are undriven inputs and all driven levels are low.
- R2: A write to a set register raises each latch bit whose write-data bit is 1 and leaves the other bits unchanged. The new value is on the pins after the clock edge that samples the write.
- R3: A write to a clear register lowers each latch bit whose write-data bit is 1 and leaves the other bits unchanged. The new value is on the pins after the clock edge that samples the write.
- R4: A direction bit of 1 drives the pin: its output enable is high. A direction bit of 0 makes the pin an input. In banks 0, 1 and 2, pin n uses bit n of every register of that bank, including the direction state readback.
- R5: A pad level appears in its input-state register on the second clock edge after it changes, never on the first. The register shows the pad level even while the pin is driven as an output.
- R6: Bank 3 pins 0..5 take their levels from bits 25..30 of the word at 0x004 (set) and 0x008 (clear). They take their directions from bits 25..30 of the word at 0x010 (set) and 0x014 (clear), and those directions read back in bits 25..30 of 0x018.
- R7: The input-state word at 0x000 packs several sources:
  - bank 3 pins 0..4 in bits 10..14;
  - bank 3 pin 5 in bit 24;
  - dedicated input k in bit k for every other k from 0 to 28.
  Dedicated inputs 10..14 and 24 have no effect, and bits 29..31 read 0.
- R8: Dedicated output k (k = 0..23) is set and cleared by bit k of 0x004 and 0x008. The word at 0x00C reads those levels back in bits 0..23 and bank 3's output latch in bits 25..30.
- R9: The bank 2 function-select latch is set at 0x028 and cleared at 0x02C, reads back at 0x030 and drives the select output.
- R10: Writes to any address outside the map change nothing, including misaligned addresses. Reads of such addresses return 0, and unused bits of mapped words read 0.
- R11: The register map is as follows.

| Bank | Input state | Output set / clear | Output state | Direction set / clear / state | Other |
|---|---|---|---|---|---|
| 0 | 0x040 | 0x044 / 0x048 | 0x04C | 0x050 / 0x054 / 0x058 | none |
| 1 | 0x060 | 0x064 / 0x068 | 0x06C | 0x070 / 0x074 / 0x078 | none |
| 2 | 0x01C | 0x020 / 0x024 | none | 0x010 / 0x014 / 0x018 | function select 0x028 / 0x02C / 0x030 |
| 3 | 0x000 | 0x004 / 0x008 | 0x00C | none | none |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| bank0_in | input | 8 | Bank 0 pad levels |
| bank0_out | output | 8 | Bank 0 driven levels |
| bank0_oe | output | 8 | Bank 0 output enables |
| bank1_in | input | 24 | Bank 1 pad levels |
| bank1_out | output | 24 | Bank 1 driven levels |
| bank1_oe | output | 24 | Bank 1 output enables |
| bank2_in | input | 13 | Bank 2 pad levels |
| bank2_out | output | 13 | Bank 2 driven levels |
| bank2_oe | output | 13 | Bank 2 output enables |
| bank2_fsel | output | 13 | Bank 2 function-select latch |
| bank3_in | input | 6 | Bank 3 pad levels |
| bank3_out | output | 6 | Bank 3 driven levels |
| bank3_oe | output | 6 | Bank 3 output enables |
| gin_pins | input | 29 | Dedicated input pads |
| gout_pins | output | 24 | Dedicated output levels |

## Verification
Assertions check several behaviours on every cycle:
- each set/clear latch obeys its mask and holds its value when it is not written;
- every synchroniser output equals its pad level from two edges earlier;
- the direction readback of bank 0 always agrees with its output enables;
- the packed bank 3 input word never carries bits above 28.

Only the directed scenarios can show the rest:
- the register map and the bit packing of bank 3 across its shared registers;
- that an unmapped or misaligned write leaves every pin untouched;
- that a pad change is invisible after one edge.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;
  // Register offsets (byte addresses); software depends on these values.
  localparam int OFS_B3_IN     = 'h000;
  localparam int OFS_B3_OSET   = 'h004;
  localparam int OFS_B3_OCLR   = 'h008;
  localparam int OFS_B3_OSTATE = 'h00C;
  localparam int OFS_B2_DSET   = 'h010;
  localparam int OFS_B2_DCLR   = 'h014;
  localparam int OFS_B2_DSTATE = 'h018;
  localparam int OFS_B2_IN     = 'h01C;
  localparam int OFS_B2_OSET   = 'h020;
  localparam int OFS_B2_OCLR   = 'h024;
  localparam int OFS_B2_FSET   = 'h028;
  localparam int OFS_B2_FCLR   = 'h02C;
  localparam int OFS_B2_FSTATE = 'h030;
  localparam int OFS_B0_IN     = 'h040;
  localparam int OFS_B0_OSET   = 'h044;
  localparam int OFS_B0_OCLR   = 'h048;
  localparam int OFS_B0_OSTATE = 'h04C;
  localparam int OFS_B0_DSET   = 'h050;
  localparam int OFS_B0_DCLR   = 'h054;
  localparam int OFS_B0_DSTATE = 'h058;
  localparam int OFS_B1_IN     = 'h060;
  localparam int OFS_B1_OSET   = 'h064;
  localparam int OFS_B1_OCLR   = 'h068;
  localparam int OFS_B1_OSTATE = 'h06C;
  localparam int OFS_B1_DSET   = 'h070;
  localparam int OFS_B1_DCLR   = 'h074;
  localparam int OFS_B1_DSTATE = 'h078;

  // Bank 3 packing inside shared words.
  localparam int B3_W       = 6;
  localparam int B3_OUT_LSB = 25;  // output latch and direction field
  localparam int B3_IN_LSB  = 10;  // pins 0..4 in the input word
  localparam int B3_IN_HI   = 24;  // last pin in the input word
endpackage

// File: rtl/gpio_sc_latch.sv
module gpio_sc_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (set_en) q <= q | mask;
    else if (clr_en) q <= q & ~mask;
  end

  p_set_forces_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(mask)) == $past(mask)));
  p_set_keeps_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));
  p_clr_forces_zeros_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(mask)) == '0));
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

  // Edges seen since reset, saturating; gates the two-deep history check.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_two_edge_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
  import gpio_rb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int B0_W   = 8,
  parameter int B1_W   = 24,
  parameter int B2_W   = 13,
  parameter int GI_W   = 29,
  parameter int GO_W   = 24,
  parameter int FS_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [B0_W-1:0]   bank0_in,
  output logic [B0_W-1:0]   bank0_out,
  output logic [B0_W-1:0]   bank0_oe,
  input  logic [B1_W-1:0]   bank1_in,
  output logic [B1_W-1:0]   bank1_out,
  output logic [B1_W-1:0]   bank1_oe,
  input  logic [B2_W-1:0]   bank2_in,
  output logic [B2_W-1:0]   bank2_out,
  output logic [B2_W-1:0]   bank2_oe,
  output logic [FS_W-1:0]   bank2_fsel,
  input  logic [B3_W-1:0]   bank3_in,
  output logic [B3_W-1:0]   bank3_out,
  output logic [B3_W-1:0]   bank3_oe,
  input  logic [GI_W-1:0]   gin_pins,
  output logic [GO_W-1:0]   gout_pins
);
  localparam int B3_HI = B3_OUT_LSB + B3_W - 1;

  function automatic logic wr_hit(input logic [ADDR_W-1:0] a, input int ofs, input logic we);
    return we && (a == ADDR_W'(ofs));
  endfunction

  // ---------------- latches ----------------
  gpio_sc_latch #(.W(B0_W)) u_b0_out (.clk, .rst_n,
    .set_en(wr_hit(bus_addr, OFS_B0_OSET, bus_we)), .clr_en(wr_hit(bus_addr, OFS_B0_OCLR, bus_we)),
    .mask(bus_wdata[B0_W-1:0]), .q(bank0_out));
  gpio_sc_latch #(.W(B0_W)) u_b0_dir (.clk, .rst_n,
    .set_en(wr_hit(bus_addr, OFS_B0_DSET, bus_we)), .clr_en(wr_hit(bus_addr, OFS_B0_DCLR, bus_we)),
    .mask(bus_wdata[B0_W-1:0]), .q(bank0_oe));
  gpio_sc_latch #(.W(B1_W)) u_b1_out (.clk, .rst_n,
    .set_en(wr_hit(bus_addr, OFS_B1_OSET, bus_we)), .clr_en(wr_hit(bus_addr, OFS_B1_OCLR, bus_we)),
    .mask(bus_wdata[B1_W-1:0]), .q(bank1_out));
  gpio_sc_latch #(.W(B1_W)) u_b1_dir (.clk, .rst_n,
    .set_en(wr_hit(bus_addr, OFS_B1_DSET, bus_we)), .clr_en(wr_hit(bus_addr, OFS_B1_DCLR, bus_we)),
    .mask(bus_wdata[B1_W-1:0]), .q(bank1_oe));
  gpio_sc_latch #(.W(B2_W)) u_b2_out (.clk, .rst_n,
    .set_en(wr_hit(bus_addr, OFS_B2_OSET, bus_we)), .clr_en(wr_hit(bus_addr, OFS_B2_OCLR, bus_we)),
    .mask(bus_wdata[B2_W-1:0]), .q(bank2_out));
  gpio_sc_latch #(.W(B2_W)) u_b2_dir (.clk, .rst_n,
    .set_en(wr_hit(bus_addr, OFS_B2_DSET, bus_we)), .clr_en(wr_hit(bus_addr, OFS_B2_DCLR, bus_we)),
    .mask(bus_wdata[B2_W-1:0]), .q(bank2_oe));
  gpio_sc_latch #(.W(FS_W)) u_b2_fsel (.clk, .rst_n,
    .set_en(wr_hit(bus_addr, OFS_B2_FSET, bus_we)), .clr_en(wr_hit(bus_addr, OFS_B2_FCLR, bus_we)),
    .mask(bus_wdata[FS_W-1:0]), .q(bank2_fsel));
  // Bank 3 direction shares bank 2's direction registers (upper field).
  gpio_sc_latch #(.W(B3_W)) u_b3_dir (.clk, .rst_n,
    .set_en(wr_hit(bus_addr, OFS_B2_DSET, bus_we)), .clr_en(wr_hit(bus_addr, OFS_B2_DCLR, bus_we)),
    .mask(bus_wdata[B3_HI:B3_OUT_LSB]), .q(bank3_oe));
  // Bank 3 levels and dedicated outputs share one set/clear pair.
  gpio_sc_latch #(.W(B3_W)) u_b3_out (.clk, .rst_n,
    .set_en(wr_hit(bus_addr, OFS_B3_OSET, bus_we)), .clr_en(wr_hit(bus_addr, OFS_B3_OCLR, bus_we)),
    .mask(bus_wdata[B3_HI:B3_OUT_LSB]), .q(bank3_out));
  gpio_sc_latch #(.W(GO_W)) u_gout (.clk, .rst_n,
    .set_en(wr_hit(bus_addr, OFS_B3_OSET, bus_we)), .clr_en(wr_hit(bus_addr, OFS_B3_OCLR, bus_we)),
    .mask(bus_wdata[GO_W-1:0]), .q(gout_pins));

  // ---------------- input synchronisers ----------------
  logic [B0_W-1:0] b0_s;
  logic [B1_W-1:0] b1_s;
  logic [B2_W-1:0] b2_s;
  logic [B3_W-1:0] b3_s;
  logic [GI_W-1:0] gi_s;
  gpio_sync2 #(.W(B0_W)) u_s0 (.clk, .rst_n, .d(bank0_in), .q(b0_s));
  gpio_sync2 #(.W(B1_W)) u_s1 (.clk, .rst_n, .d(bank1_in), .q(b1_s));
  gpio_sync2 #(.W(B2_W)) u_s2 (.clk, .rst_n, .d(bank2_in), .q(b2_s));
  gpio_sync2 #(.W(B3_W)) u_s3 (.clk, .rst_n, .d(bank3_in), .q(b3_s));
  gpio_sync2 #(.W(GI_W)) u_sg (.clk, .rst_n, .d(gin_pins), .q(gi_s));

  // Packed bank 3 input word: dedicated inputs with bank 3 pins overlaid.
  logic [31:0] b3_in_word;
  always_comb begin
    b3_in_word = '0;
    b3_in_word[GI_W-1:0] = gi_s;
    b3_in_word[B3_IN_LSB +: B3_W-1] = b3_s[B3_W-2:0];
    b3_in_word[B3_IN_HI] = b3_s[B3_W-1];
  end

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_B3_IN):     bus_rdata = b3_in_word;
      ADDR_W'(OFS_B3_OSTATE): begin
        bus_rdata[GO_W-1:0]         = gout_pins;
        bus_rdata[B3_HI:B3_OUT_LSB] = bank3_out;
      end
      ADDR_W'(OFS_B2_DSTATE): begin
        bus_rdata[B2_W-1:0]         = bank2_oe;
        bus_rdata[B3_HI:B3_OUT_LSB] = bank3_oe;
      end
      ADDR_W'(OFS_B2_IN):     bus_rdata[B2_W-1:0] = b2_s;
      ADDR_W'(OFS_B2_FSTATE): bus_rdata[FS_W-1:0] = bank2_fsel;
      ADDR_W'(OFS_B0_IN):     bus_rdata[B0_W-1:0] = b0_s;
      ADDR_W'(OFS_B0_OSTATE): bus_rdata[B0_W-1:0] = bank0_out;
      ADDR_W'(OFS_B0_DSTATE): bus_rdata[B0_W-1:0] = bank0_oe;
      ADDR_W'(OFS_B1_IN):     bus_rdata[B1_W-1:0] = b1_s;
      ADDR_W'(OFS_B1_OSTATE): bus_rdata[B1_W-1:0] = bank1_out;
      ADDR_W'(OFS_B1_DSTATE): bus_rdata[B1_W-1:0] = bank1_oe;
      default:                bus_rdata = '0;
    endcase
  end

  p_dir_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_B0_DSTATE)) |-> (bus_rdata[B0_W-1:0] == bank0_oe));
  p_b3_in_top_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_B3_IN)) |-> (bus_rdata[31:GI_W] == '0));
endmodule

// File: tb/sim_gpio_regblock.sv
`timescale 1ns/1ps
module sim_gpio_regblock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  bank0_in = '0, bank0_out, bank0_oe;
  logic [23:0] bank1_in = '0, bank1_out, bank1_oe;
  logic [12:0] bank2_in = '0, bank2_out, bank2_oe, bank2_fsel;
  logic [5:0]  bank3_in = '0, bank3_out, bank3_oe;
  logic [28:0] gin_pins = '0;
  logic [23:0] gout_pins;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_regblock u0 (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .bank0_in, .bank0_out, .bank0_oe, .bank1_in, .bank1_out, .bank1_oe,
    .bank2_in, .bank2_out, .bank2_oe, .bank2_fsel,
    .bank3_in, .bank3_out, .bank3_oe, .gin_pins, .gout_pins);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 bank0_out", 32'(bank0_out), 0);
    chk("R1 oe all", {bank0_oe, bank1_oe} , 0);
    chk("R1 bank2/3 oe", 32'({bank2_oe, bank3_oe}), 0);
    chk("R1 gout/fsel", 32'({gout_pins}) | 32'(bank2_fsel), 0);
    rd(8'h18, v); chk("R1 dir state", v, 0);
  endtask

  task automatic t_set_clear();
    logic [31:0] v;
    wr(8'h44, 32'hFFFF_FFA5); chk("R2 bank0 set", 32'(bank0_out), 32'hA5);
    wr(8'h44, 32'h0F);        chk("R2 bank0 set keeps", 32'(bank0_out), 32'hAF);
    wr(8'h48, 32'h81);        chk("R3 bank0 clear", 32'(bank0_out), 32'h2E);
    rd(8'h4C, v);             chk("R11 bank0 out state", v, 32'h2E);
    wr(8'h64, 32'h00F0_0F01); wr(8'h68, 32'h0000_0F00);
    rd(8'h6C, v);             chk("R3 bank1 state", v, 32'h00F0_0001);
    wr(8'h20, 32'h1FFF);      wr(8'h24, 32'h0AAA);
    chk("R2 bank2 out", 32'(bank2_out), 32'h1555);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(8'h50, 32'hF0);  chk("R4 bank0 oe", 32'(bank0_oe), 32'hF0);
    rd(8'h58, v);       chk("R4 bank0 dir state", v, 32'hF0);
    wr(8'h70, 32'h80_0001); wr(8'h74, 32'h1);
    rd(8'h78, v);       chk("R4 bank1 dir state", v, 32'h80_0000);
    chk("R4 bank1 oe bit23", 32'(bank1_oe), 32'h80_0000);
    wr(8'h10, 32'h0000_0008); chk("R4 bank2 oe bit3", 32'(bank2_oe), 32'h8);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    @(negedge clk); bank0_in = 8'h3C;
    rd(8'h40, v); chk("R5 not after one edge", v, 0);
    rd(8'h40, v); chk("R5 after two edges (pins 4,5 driven)", v, 32'h3C);
    @(negedge clk); bank2_in = 13'h1001;
    rd(8'h1C, v); rd(8'h1C, v); chk("R5 bank2 input", v, 32'h1001);
  endtask

  task automatic t_bank3();
    logic [31:0] v, exp;
    wr(8'h04, (32'h2D << 25) | 32'h12_3456);
    chk("R6 bank3 out", 32'(bank3_out), 32'h2D);
    chk("R8 gout", 32'(gout_pins), 32'h12_3456);
    wr(8'h08, (32'h05 << 25) | 32'h00_0450);
    rd(8'h0C, v); chk("R8 out state word", v, (32'h28 << 25) | 32'h12_3006);
    wr(8'h10, 32'h1 << 27);
    chk("R6 bank3 oe pin2", 32'(bank3_oe), 32'h04);
    chk("R6 bank2 oe untouched", 32'(bank2_oe), 32'h8);
    rd(8'h18, v); chk("R6 dir state word", v, (32'h1 << 27) | 32'h8);
    @(negedge clk); bank3_in = 6'b100110; gin_pins = 29'h1FFF_FFFF;
    rd(8'h00, v); rd(8'h00, v);
    exp = (32'h1FFF_FFFF & ~(32'h1F << 10) & ~(32'h1 << 24)) | (32'h06 << 10) | (32'h1 << 24);
    chk("R7 packed input word", v, exp);
    @(negedge clk); bank3_in = 6'b000000;
    rd(8'h00, v); rd(8'h00, v);
    chk("R7 gin 10..14,24 ignored", v, exp & ~(32'h06 << 10) & ~(32'h1 << 24));
  endtask

  task automatic t_fsel();
    logic [31:0] v;
    wr(8'h28, 32'h1F0F); wr(8'h2C, 32'h0F00);
    chk("R9 fsel pins", 32'(bank2_fsel), 32'h100F);
    rd(8'h30, v); chk("R9 fsel state", v, 32'h100F);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    logic [7:0]  o0, d0;
    logic [23:0] g;
    o0 = bank0_out; d0 = bank0_oe; g = gout_pins;
    wr(8'h34, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h45, 32'hFFFF_FFFF); wr(8'h7C, 32'hFFFF_FFFF); wr(8'h05, 32'hFFFF_FFFF);
    chk("R10 bank0 out unchanged", 32'(bank0_out), 32'(o0));
    chk("R10 bank0 oe unchanged", 32'(bank0_oe), 32'(d0));
    chk("R10 gout unchanged", 32'(gout_pins), 32'(g));
    rd(8'h34, v); chk("R10 unmapped read", v, 0);
    rd(8'h4D, v); chk("R10 misaligned read", v, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_clear();
    t_dir();
    t_sync();
    t_bank3();
    t_fsel();
    t_unmapped();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule